// File: doc/BRIEF.md
# Prescaled Periodic Down-Counter Timer

A single-channel, memory-mapped timer peripheral on a simple register bus with a 32-bit data path. It has two counting paths, and both are clocked from the bus clock. The first path is a down-counter. Its tick comes from a 10-bit predivider followed by a selectable divide-by-1/16/256 prescaler. The counter runs only in periodic mode: when a tick arrives while it holds zero, it reloads from the reload register and raises a raw interrupt flag. The second path is an independent 32-bit up-counter that runs freely, with its own 8-bit divider held in the control register.

Software programs the start value through the load register, which sets the current value and the reload value together. The reload register changes only the value used at the next wrap. Software acknowledges an interrupt by writing any value to the clear register. The level interrupt output follows the raw flag gated by the interrupt enable. The counter width can be set to 16 or 32 bits. In 16-bit size, values are taken modulo 2^16.

Top module: `tick_timer`

## Requirements
- R1: After reset, the control register reads 0x003E0020, the predivider reads 0x07D, and the current value, raw flag, free-running count and `irq` are all zero.
- R2: Word registers are decoded from byte address bits [5:2], in this order: 0x00 load, 0x04 current value, 0x08 control, 0x0C interrupt clear, 0x10 raw flag, 0x14 masked flag, 0x18 reload, 0x1C predivider, 0x20 free-running count. The load and reload offsets both read the reload value. Writes to the current value, raw and masked offsets have no effect. Control reads return only its fields, with every other bit reading zero.
- R3: Control fields are: [23:16] free-running divider, [9] free-running enable, [7] timer enable, [5] interrupt enable, [3:2] prescale, [1] size (1 = 32-bit). While the timer is enabled, the value decrements once every (predivider+1)×S bus cycles, where the prescale field gives S: 00 → 1, 01 → 16, 10 → 256, 11 → 1.
- R4: The predivider is 10 bits wide and reads back what was written, truncated to 10 bits. A write to it restarts both the predivider count and the prescale count.
- R5: A tick that arrives while the value is zero loads the reload value and sets the raw flag.
- R6: A write to load sets both the current value and the reload value at that clock edge. A write to reload changes only the value used at the next wrap.
- R7: A write of zero to load sets the raw flag at that clock edge.
- R8: A write of any data to the interrupt clear offset clears the raw flag. A flag set in the same cycle takes priority over the clear.
- R9: The masked flag equals raw AND interrupt enable, and `irq` equals the masked flag.
- R10: In 16-bit size, load and reload data are truncated to bits [15:0], and the current value reads with bits [31:16] zero.
- R11: While the free-running enable is set, the free-running count increments once every (divider+1) bus cycles.
- R12: While an enable is clear, its counter and divider counts hold their state. On re-enable, counting resumes from that state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, also the count source |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 6 | Byte address in the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq | output | 1 | Level interrupt |

## Verification
On every cycle, the assertions check the following: load writes reach the current value, zero loads and wraps raise the flag, a clear lowers it, and disabled counters and divider counts stay frozen. They also check that the free-running count advances by at most one per cycle and that a 16-bit value reads with zero upper bits. The exact tick periods for each prescale code and predivider value need the bench's directed scenarios, because the assertions cannot show them. The same is true of resuming mid-period after a disable, of reload-only writes taking effect at the next wrap, and of the free-running rate.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

    localparam int WORD_W   = 32;
    localparam int ADDR_W   = 6;
    localparam int PREDIV_W = 10;
    localparam int FDIV_W   = 8;
    localparam int PSC_W    = 8;

    typedef enum logic [3:0] {
        REG_LOAD   = 4'd0,
        REG_VALUE  = 4'd1,
        REG_CTRL   = 4'd2,
        REG_ICLR   = 4'd3,
        REG_RAW    = 4'd4,
        REG_MSK    = 4'd5,
        REG_RELOAD = 4'd6,
        REG_PREDIV = 4'd7,
        REG_FRC    = 4'd8
    } reg_idx_e;

    typedef struct packed {
        logic [FDIV_W-1:0] frc_div;
        logic              frc_en;
        logic              run;
        logic              irq_en;
        logic [1:0]        psc;
        logic              wide;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{
        frc_div: 8'h3E, frc_en: 1'b0, run: 1'b0,
        irq_en: 1'b1, psc: 2'b00, wide: 1'b0
    };
    localparam logic [PREDIV_W-1:0] PREDIV_RESET = 10'h07D;

    function automatic ctrl_t ctrl_from_word(input logic [WORD_W-1:0] w);
        ctrl_t c;
        c.frc_div = w[23:16];
        c.frc_en  = w[9];
        c.run     = w[7];
        c.irq_en  = w[5];
        c.psc     = w[3:2];
        c.wide    = w[1];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] ctrl_to_word(input ctrl_t c);
        logic [WORD_W-1:0] w;
        w        = '0;
        w[23:16] = c.frc_div;
        w[9]     = c.frc_en;
        w[7]     = c.run;
        w[5]     = c.irq_en;
        w[3:2]   = c.psc;
        w[1]     = c.wide;
        return w;
    endfunction

    // Terminal count of the prescale stage (divide ratio minus one).
    function automatic logic [PSC_W-1:0] psc_last(input logic [1:0] sel);
        case (sel)
            2'b01:   return PSC_W'(15);
            2'b10:   return PSC_W'(255);
            default: return '0;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] size_mask(input logic wide);
        return wide ? {WORD_W{1'b1}} : {{(WORD_W-16){1'b0}}, 16'hFFFF};
    endfunction

endpackage

// File: rtl/tick_timer_prescale.sv
module tick_timer_prescale
    import tick_timer_pkg::*;
#(
    parameter int PW = PREDIV_W,
    parameter int SW = PSC_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          restart,
    input  logic [PW-1:0] prediv,
    input  logic [SW-1:0] last,
    output logic          tick
);

    logic [PW-1:0] pcnt;
    logic [SW-1:0] scnt;
    logic          pre_hit;
    logic          scl_hit;

    assign pre_hit = en && (pcnt >= prediv);
    assign scl_hit = (scnt >= last);
    assign tick    = pre_hit && scl_hit;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            pcnt <= '0;
            scnt <= '0;
        end else if (en) begin
            if (pre_hit) begin
                pcnt <= '0;
                scnt <= scl_hit ? '0 : scnt + SW'(1);
            end else begin
                pcnt <= pcnt + PW'(1);
            end
        end
    end

    // R12: a disabled divider keeps its counts
    a_r12_div_hold: assert property (@(posedge clk) disable iff (rst)
        (!en && !restart) |=> ($stable(pcnt) && $stable(scnt)));

    // R4: a predivider write starts a fresh period
    a_r4_restart_clears: assert property (@(posedge clk) disable iff (rst)
        restart |=> (pcnt == '0 && scnt == '0));

endmodule

// File: rtl/tick_timer_down.sv
module tick_timer_down
    import tick_timer_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         wide,
    input  logic         load_we,
    input  logic         reload_we,
    input  logic         clr_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] value,
    output logic [W-1:0] reload,
    output logic         raw
);

    logic [W-1:0] mask;
    logic [W-1:0] wmask;
    logic [W-1:0] cur;
    logic         at_zero;
    logic         wrap_evt;
    logic         zero_load;

    assign mask      = size_mask(wide);
    assign wmask     = wdata & mask;
    assign cur       = value & mask;
    assign at_zero   = (cur == '0);
    assign wrap_evt  = tick && at_zero && !load_we;
    assign zero_load = load_we && (wmask == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            value  <= '0;
            reload <= '0;
        end else if (load_we) begin
            value  <= wmask;
            reload <= wmask;
        end else begin
            if (reload_we) begin
                reload <= wmask;
            end
            if (tick) begin
                value <= at_zero ? (reload & mask) : (cur - W'(1));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            raw <= 1'b0;
        end else if (wrap_evt || zero_load) begin
            raw <= 1'b1;
        end else if (clr_we) begin
            raw <= 1'b0;
        end
    end

    // R6: load takes effect at once
    a_r6_load_value: assert property (@(posedge clk) disable iff (rst)
        load_we |=> (value == $past(wmask) && reload == $past(wmask)));

    // R7: zero load raises the flag
    a_r7_zero_load: assert property (@(posedge clk) disable iff (rst)
        (load_we && wdata[15:0] == 16'h0 && (!wide || wdata[W-1:16] == '0)) |=> raw);

    // R5: wrap reloads and flags
    a_r5_wrap_reload: assert property (@(posedge clk) disable iff (rst)
        (tick && !load_we && cur == '0) |=> (raw && value == $past(reload & mask)));

    // R8: clear without a competing set drops the flag
    a_r8_clear: assert property (@(posedge clk) disable iff (rst)
        (clr_we && !load_we && !tick) |=> !raw);

    // R12: without a tick or load the value holds
    a_r12_value_hold: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load_we) |=> $stable(value));

endmodule

// File: rtl/tick_timer_frc.sv
module tick_timer_frc
    import tick_timer_pkg::*;
#(
    parameter int CW = WORD_W,
    parameter int DW = FDIV_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [DW-1:0] div,
    output logic [CW-1:0] count
);

    logic [DW-1:0] dcnt;
    logic          step;

    assign step = en && (dcnt >= div);

    always_ff @(posedge clk) begin
        if (rst) begin
            dcnt  <= '0;
            count <= '0;
        end else if (en) begin
            if (step) begin
                dcnt  <= '0;
                count <= count + CW'(1);
            end else begin
                dcnt <= dcnt + DW'(1);
            end
        end
    end

    // R11: at most one increment per cycle
    a_r11_single_step: assert property (@(posedge clk) disable iff (rst)
        en |=> (count == $past(count) || count == $past(count) + CW'(1)));

    // R12: disabled counter and divider are frozen
    a_r12_frc_hold: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(count) && $stable(dcnt)));

endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              irq
);

    ctrl_t                ctrl_q;
    logic [PREDIV_W-1:0]  prediv_q;
    reg_idx_e             idx;
    logic                 aligned;
    logic                 wr;
    logic                 we_load, we_ctrl, we_iclr, we_reload, we_prediv;
    logic                 tick;
    logic [WORD_W-1:0]    value;
    logic [WORD_W-1:0]    reload;
    logic                 raw;
    logic [WORD_W-1:0]    frc_count;
    logic                 masked;

    assign idx       = reg_idx_e'(bus_addr[ADDR_W-1:2]);
    assign aligned   = (bus_addr[1:0] == 2'b00);
    assign wr        = bus_sel && bus_wr && aligned;
    assign we_load   = wr && (idx == REG_LOAD);
    assign we_ctrl   = wr && (idx == REG_CTRL);
    assign we_iclr   = wr && (idx == REG_ICLR);
    assign we_reload = wr && (idx == REG_RELOAD);
    assign we_prediv = wr && (idx == REG_PREDIV);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= CTRL_RESET;
            prediv_q <= PREDIV_RESET;
        end else begin
            if (we_ctrl) begin
                ctrl_q <= ctrl_from_word(bus_wdata);
            end
            if (we_prediv) begin
                prediv_q <= bus_wdata[PREDIV_W-1:0];
            end
        end
    end

    tick_timer_prescale #(.PW(PREDIV_W), .SW(PSC_W)) u_prescale (
        .clk     (clk),
        .rst     (rst),
        .en      (ctrl_q.run),
        .restart (we_prediv),
        .prediv  (prediv_q),
        .last    (psc_last(ctrl_q.psc)),
        .tick    (tick)
    );

    tick_timer_down #(.W(WORD_W)) u_down (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .wide      (ctrl_q.wide),
        .load_we   (we_load),
        .reload_we (we_reload),
        .clr_we    (we_iclr),
        .wdata     (bus_wdata),
        .value     (value),
        .reload    (reload),
        .raw       (raw)
    );

    tick_timer_frc #(.CW(WORD_W), .DW(FDIV_W)) u_frc (
        .clk   (clk),
        .rst   (rst),
        .en    (ctrl_q.frc_en),
        .div   (ctrl_q.frc_div),
        .count (frc_count)
    );

    assign masked = raw && ctrl_q.irq_en;
    assign irq    = masked;

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            case (idx)
                REG_LOAD:   bus_rdata = reload;
                REG_VALUE:  bus_rdata = value & size_mask(ctrl_q.wide);
                REG_CTRL:   bus_rdata = ctrl_to_word(ctrl_q);
                REG_RAW:    bus_rdata = {{(WORD_W-1){1'b0}}, raw};
                REG_MSK:    bus_rdata = {{(WORD_W-1){1'b0}}, masked};
                REG_RELOAD: bus_rdata = reload;
                REG_PREDIV: bus_rdata = {{(WORD_W-PREDIV_W){1'b0}}, prediv_q};
                REG_FRC:    bus_rdata = frc_count;
                default:    bus_rdata = '0;
            endcase
        end
    end

    // R10: 16-bit value reads carry no upper bits
    a_r10_narrow_read: assert property (@(posedge clk) disable iff (rst)
        (aligned && idx == REG_VALUE && !ctrl_q.wide) |-> (bus_rdata[31:16] == 16'h0));

    // R2: reserved control bits read zero
    a_r2_ctrl_reserved: assert property (@(posedge clk) disable iff (rst)
        (aligned && idx == REG_CTRL) |->
        (bus_rdata[31:24] == 8'h0 && bus_rdata[15:10] == 6'h0 &&
         !bus_rdata[8] && !bus_rdata[6] && !bus_rdata[4] && !bus_rdata[0]));

    // R9: a clear with no pending set and no tick drops the interrupt
    a_r9_irq_clear: assert property (@(posedge clk) disable iff (rst)
        (we_iclr && !tick) |=> !irq);

endmodule

// File: tb/test_tick_timer.sv
module test_tick_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    localparam logic [5:0] A_LOAD = 6'h00, A_VALUE = 6'h04, A_CTRL = 6'h08,
        A_ICLR = 6'h0C, A_RAW = 6'h10, A_MSK = 6'h14, A_RELOAD = 6'h18,
        A_PREDIV = 6'h1C, A_FRC = 6'h20;

    always #10 clk = ~clk;

    tick_timer i_tick_timer (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic logic [31:0] cw(input logic [7:0] fdiv, input logic fen,
        input logic run, input logic ie, input logic [1:0] psc, input logic wide);
        return {8'h0, fdiv, 6'h0, fen, 1'b0, run, 1'b0, ie, 1'b0, psc, wide, 1'b0};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Called at a negedge; the following posedge performs the write.
    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic chk_reg(input string req, input logic [5:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        chk_reg("R1 ctrl", A_CTRL, 32'h003E0020);
        chk_reg("R1 prediv", A_PREDIV, 32'h0000007D);
        chk_reg("R1 value", A_VALUE, 32'h0);
        chk_reg("R1 raw", A_RAW, 32'h0);
        chk_reg("R1 frc", A_FRC, 32'h0);
        chk("R1 irq", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_count();
        wr(A_PREDIV, 32'h0);
        wr(A_LOAD, 32'd5);
        wr(A_CTRL, cw(8'h3E, 0, 1, 1, 2'b00, 1));
        chk_reg("R3 value at enable", A_VALUE, 32'd5);
        cycles(3);
        chk_reg("R3 div1 decrement", A_VALUE, 32'd2);
        cycles(2);
        chk_reg("R5 reach zero", A_VALUE, 32'd0);
        chk_reg("R5 no flag before wrap", A_RAW, 32'd0);
        cycles(1);
        chk_reg("R5 reload on wrap", A_VALUE, 32'd5);
        chk_reg("R5 raw set", A_RAW, 32'd1);
        chk("R9 irq follows raw", {31'h0, irq}, 32'd1);
        wr(A_CTRL, cw(8'h3E, 0, 0, 1, 2'b00, 1));
        wr(A_ICLR, 32'h0);
    endtask

    task automatic t_prescale();
        wr(A_PREDIV, 32'h0);
        wr(A_LOAD, 32'd3);
        wr(A_CTRL, cw(8'h3E, 0, 1, 1, 2'b01, 1));
        cycles(15);
        chk_reg("R3 div16 before", A_VALUE, 32'd3);
        cycles(1);
        chk_reg("R3 div16 tick", A_VALUE, 32'd2);
        wr(A_CTRL, cw(8'h3E, 0, 1, 1, 2'b11, 1));
        cycles(1);
        chk_reg("R3 code 11 divides by 1", A_VALUE, 32'd1);
        wr(A_CTRL, cw(8'h3E, 0, 0, 1, 2'b00, 1));
        wr(A_PREDIV, 32'h0);
        wr(A_LOAD, 32'd3);
        wr(A_CTRL, cw(8'h3E, 0, 1, 1, 2'b10, 1));
        cycles(255);
        chk_reg("R3 div256 before", A_VALUE, 32'd3);
        cycles(1);
        chk_reg("R3 div256 tick", A_VALUE, 32'd2);
        wr(A_CTRL, cw(8'h3E, 0, 0, 1, 2'b00, 1));
        wr(A_ICLR, 32'h0);
    endtask

    task automatic t_prediv();
        wr(A_PREDIV, 32'h3);
        chk_reg("R4 readback", A_PREDIV, 32'h3);
        wr(A_LOAD, 32'd9);
        wr(A_CTRL, cw(8'h3E, 0, 1, 1, 2'b00, 1));
        cycles(3);
        chk_reg("R4 prediv3 before", A_VALUE, 32'd9);
        cycles(1);
        chk_reg("R4 prediv3 tick", A_VALUE, 32'd8);
        cycles(4);
        chk_reg("R4 prediv3 period", A_VALUE, 32'd7);
        wr(A_CTRL, cw(8'h3E, 0, 0, 1, 2'b00, 1));
        wr(A_PREDIV, 32'hFFFFFFFF);
        chk_reg("R4 truncated to 10 bits", A_PREDIV, 32'h3FF);
    endtask

    task automatic t_hold();
        wr(A_PREDIV, 32'h3);
        wr(A_LOAD, 32'd10);
        wr(A_CTRL, cw(8'h3E, 0, 1, 1, 2'b00, 1));
        cycles(2);
        wr(A_CTRL, cw(8'h3E, 0, 0, 1, 2'b00, 1));
        cycles(10);
        chk_reg("R12 value held", A_VALUE, 32'd10);
        wr(A_CTRL, cw(8'h3E, 0, 1, 1, 2'b00, 1));
        chk_reg("R12 value after re-enable", A_VALUE, 32'd10);
        cycles(1);
        chk_reg("R12 resume mid-period", A_VALUE, 32'd9);
        wr(A_CTRL, cw(8'h3E, 0, 0, 1, 2'b00, 1));
    endtask

    task automatic t_zero_load();
        wr(A_ICLR, 32'h0);
        chk_reg("R8 cleared", A_RAW, 32'd0);
        wr(A_LOAD, 32'h0);
        chk_reg("R7 zero load raw", A_RAW, 32'd1);
        chk_reg("R9 masked", A_MSK, 32'd1);
        chk("R7 irq", {31'h0, irq}, 32'd1);
        wr(A_ICLR, 32'h1234);
        chk_reg("R8 any data clears", A_RAW, 32'd0);
        chk("R8 irq low", {31'h0, irq}, 32'd0);
    endtask

    task automatic t_mask();
        wr(A_CTRL, cw(8'h3E, 0, 0, 0, 2'b00, 1));
        wr(A_LOAD, 32'h0);
        chk_reg("R9 raw with ie=0", A_RAW, 32'd1);
        chk_reg("R9 masked with ie=0", A_MSK, 32'd0);
        chk("R9 irq with ie=0", {31'h0, irq}, 32'd0);
        wr(A_CTRL, cw(8'h3E, 0, 0, 1, 2'b00, 1));
        chk("R9 irq with ie=1", {31'h0, irq}, 32'd1);
        wr(A_ICLR, 32'h0);
    endtask

    task automatic t_regs_size();
        wr(A_CTRL, 32'hFF3EFD73);
        chk_reg("R2 ctrl reserved bits", A_CTRL, 32'h003E0022);
        wr(A_LOAD, 32'h0001_2345);
        wr(A_VALUE, 32'hAAAA_AAAA);
        chk_reg("R2 value write ignored", A_VALUE, 32'h0001_2345);
        wr(A_RAW, 32'h1);
        chk_reg("R2 raw write ignored", A_RAW, 32'h0);
        wr(A_CTRL, cw(8'h3E, 0, 0, 1, 2'b00, 0));
        chk_reg("R10 narrow read", A_VALUE, 32'h0000_2345);
        wr(A_LOAD, 32'h0001_2345);
        chk_reg("R10 load truncated", A_LOAD, 32'h0000_2345);
        wr(A_CTRL, cw(8'h3E, 0, 0, 1, 2'b00, 1));
        wr(A_LOAD, 32'h0001_2345);
        chk_reg("R10 wide load", A_VALUE, 32'h0001_2345);
    endtask

    task automatic t_reload();
        wr(A_ICLR, 32'h0);
        wr(A_PREDIV, 32'h0);
        wr(A_LOAD, 32'd2);
        wr(A_CTRL, cw(8'h3E, 0, 1, 1, 2'b00, 1));
        wr(A_RELOAD, 32'd7);
        chk_reg("R6 reload write keeps value", A_VALUE, 32'd1);
        chk_reg("R6 load offset reads reload", A_LOAD, 32'd7);
        cycles(1);
        chk_reg("R6 count to zero", A_VALUE, 32'd0);
        cycles(1);
        chk_reg("R6 new reload at wrap", A_VALUE, 32'd7);
        chk_reg("R5 raw at wrap", A_RAW, 32'd1);
        wr(A_CTRL, cw(8'h3E, 0, 0, 1, 2'b00, 1));
        wr(A_ICLR, 32'h0);
    endtask

    task automatic t_frc();
        wr(A_CTRL, cw(8'h02, 1, 0, 1, 2'b00, 1));
        chk_reg("R11 start", A_FRC, 32'd0);
        cycles(2);
        chk_reg("R11 before step", A_FRC, 32'd0);
        cycles(1);
        chk_reg("R11 first step", A_FRC, 32'd1);
        cycles(6);
        chk_reg("R11 rate", A_FRC, 32'd3);
        wr(A_CTRL, cw(8'h02, 0, 0, 1, 2'b00, 1));
        cycles(5);
        chk_reg("R12 frc held", A_FRC, 32'd3);
    endtask

    initial begin
        cycles(3);
        rst = 1'b0;
        t_reset();
        t_count();
        t_prescale();
        t_prediv();
        t_hold();
        t_zero_load();
        t_mask();
        t_regs_size();
        t_reload();
        t_frc();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule